// File: doc/BRIEF.md
# Token-Ring Depth-Cascaded FIFO

This block builds one deep first-in/first-out buffer out of a ring of identical storage slices. All slices see the same write strobe, write data, read strobe and read-data path. Two privileges go around the ring: a write token and a read token. Only the slice that holds the write token stores an incoming word. Only the slice that holds the read token answers a read. A slice fills its locations in order from location zero. When it writes its last physical location, it raises a one-cycle expansion pulse toward the next slice and gives up the write token on that same clock edge. Reads pass the read token in the same way. The last slice's expansion output wraps back to the first slice.

A per-slice first-load input chooses the slice that holds both tokens after reset. The system must tie exactly one slice's input low, and that slice is where storage begins. Each slice reports its own full and empty flags. The wrapper combines them into composite flags that are asserted only when every slice agrees. This mode has no half-full or retransmit function.

Each slice has a small token state machine with four named states:
- `TK_NONE`: the slice holds neither token.
- `TK_WR`: the slice holds only the write token.
- `TK_RD`: the slice holds only the read token.
- `TK_BOTH`: the slice holds both tokens.

In every state, a gain pulse from the previous slice adds the matching token. A last-location access removes the matching token. When both happen for the same token on one edge (a ring of one slice), the token stays. The reset state is `TK_BOTH` for the first-load slice and `TK_NONE` for all others.

Top module: `tokring_fifo`

## Requirements
- R1: During and straight after reset, the slice whose `first_load_n` bit is 0 holds both tokens and every other slice holds neither. Every slice is empty. The composite `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: Exactly one slice holds the write token. That slice alone stores an accepted write, and it fills its locations in order starting at location 0.
- R3: When the write-token slice stores a word at location DEPTH-1, the write token moves to slice (index+1) mod NSLICE on that same clock edge, and slice NSLICE-1 passes it to slice 0.
- R4: Exactly one slice holds the read token. A read of location DEPTH-1 moves the read token to slice (index+1) mod NSLICE on that same edge.
- R5: An accepted read sets `rd_valid` to 1 on the cycle after the read strobe, with `rd_data` holding the oldest stored word. Data leaves in the order it was written, across slice boundaries.
- R6: `empty` is 1 exactly when every slice holds no data. A read strobe while `empty` is 1 is ignored: `rd_valid` stays 0 and the read token does not move.
- R7: `full` is 1 exactly when all NSLICE*DEPTH locations hold data. A write strobe while `full` is 1 is ignored, and the dropped word never appears at the read port.
- R8: Bit s of `slice_full` is 1 when slice s holds DEPTH words, and bit s of `slice_empty` is 1 when slice s holds none.
- R9: A write and a read in the same cycle both take effect when the buffer is neither empty nor full.
- R10: Any slice can be the first-load slice. Storage and reading then begin at that slice and go around the ring from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_load_n | input | NSLICE | Per-slice first-load select; exactly one bit is 0 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Read data, valid when `rd_valid` is 1 |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| full | output | 1 | Composite full (all slices full) |
| empty | output | 1 | Composite empty (all slices empty) |
| slice_full | output | NSLICE | Per-slice full flags |
| slice_empty | output | NSLICE | Per-slice empty flags |
| wr_tok | output | NSLICE | Per-slice write-token flags |
| rd_tok | output | NSLICE | Per-slice read-token flags |

## Verification
The bench drives the buffer to full and then keeps writing, drains it to empty and then keeps reading, and applies simultaneous reads and writes around both boundaries. Each case targets a specific defect:
- A design that stored a word while full would later return that word in place of the expected sequence.
- A design that answered a read while empty would raise a spurious `rd_valid`.
- A slice that passed its token one location early or late, or at the wrong edge, would show the tokens on the wrong slice and deliver words out of order.
- Restarting with a different first-load slice checks that the ring wraps from the last slice to slice 0. A design that hard-wired slice 0 as the start would fail this check.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_WR   = 2'd1,
        TK_RD   = 2'd2,
        TK_BOTH = 2'd3
    } tok_state_t;
endpackage

// File: rtl/tokring_tokfsm.sv
module tokring_tokfsm
    import tokring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_n,
    input  logic wr_gain,
    input  logic rd_gain,
    input  logic wr_pass,
    input  logic rd_pass,
    output logic has_wr,
    output logic has_rd
);
    tok_state_t state, nxt;
    logic keep_wr, keep_rd;

    // A pass and a gain on the same edge only occur in a single-slice ring
    always_comb begin
        keep_wr = wr_gain;
        keep_rd = rd_gain;
        unique case (state)
            TK_NONE: begin
                keep_wr = wr_gain;
                keep_rd = rd_gain;
            end
            TK_WR: begin
                keep_wr = !wr_pass || wr_gain;
                keep_rd = rd_gain;
            end
            TK_RD: begin
                keep_wr = wr_gain;
                keep_rd = !rd_pass || rd_gain;
            end
            TK_BOTH: begin
                keep_wr = !wr_pass || wr_gain;
                keep_rd = !rd_pass || rd_gain;
            end
        endcase
        nxt = tok_state_t'({keep_rd, keep_wr});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= first_n ? TK_NONE : TK_BOTH;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            TK_NONE: begin has_wr = 1'b0; has_rd = 1'b0; end
            TK_WR:   begin has_wr = 1'b1; has_rd = 1'b0; end
            TK_RD:   begin has_wr = 1'b0; has_rd = 1'b1; end
            TK_BOTH: begin has_wr = 1'b1; has_rd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/tokring_store.sv
module tokring_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             has_wr,
    input  logic             has_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             is_full,
    output logic             is_empty,
    output logic             wr_last,
    output logic             rd_last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             wr_go, rd_go;

    assign is_full  = (cnt == CAP);
    assign is_empty = (cnt == '0);
    assign wr_go    = wr_en && has_wr && !is_full;
    assign rd_go    = rd_en && has_rd && !is_empty;
    assign wr_last  = wr_go && (wptr == LAST);
    assign rd_last  = rd_go && (rptr == LAST);

    always_ff @(posedge clk) begin
        if (wr_go) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            cnt      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_go) begin
                rd_data <= mem[rptr];
                rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            if (wr_go && !rd_go)      cnt <= cnt + 1'b1;
            else if (rd_go && !wr_go) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tokring_slice.sv
module tokring_slice #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr,
    output logic             xo_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             is_full,
    output logic             is_empty,
    output logic             has_wr,
    output logic             has_rd
);
    tokring_tokfsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_n (first_n),
        .wr_gain (xi_wr),
        .rd_gain (xi_rd),
        .wr_pass (xo_wr),
        .rd_pass (xo_rd),
        .has_wr  (has_wr),
        .has_rd  (has_rd)
    );

    tokring_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .has_wr   (has_wr),
        .has_rd   (has_rd),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .is_full  (is_full),
        .is_empty (is_empty),
        .wr_last  (xo_wr),
        .rd_last  (xo_rd)
    );
endmodule

// File: rtl/tokring_fifo.sv
module tokring_fifo #(
    parameter int NSLICE = 3,
    parameter int WIDTH  = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLICE-1:0] first_load_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic [NSLICE-1:0] slice_full,
    output logic [NSLICE-1:0] slice_empty,
    output logic [NSLICE-1:0] wr_tok,
    output logic [NSLICE-1:0] rd_tok
);
    logic [NSLICE-1:0] xo_wr, xo_rd, vld;
    logic [WIDTH-1:0]  dat [NSLICE];

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        localparam int PREV = (s + NSLICE - 1) % NSLICE;
        tokring_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .first_n  (first_load_n[s]),
            .wr_en    (wr_en),
            .wr_data  (wr_data),
            .rd_en    (rd_en),
            .xi_wr    (xo_wr[PREV]),
            .xi_rd    (xo_rd[PREV]),
            .xo_wr    (xo_wr[s]),
            .xo_rd    (xo_rd[s]),
            .rd_data  (dat[s]),
            .rd_valid (vld[s]),
            .is_full  (slice_full[s]),
            .is_empty (slice_empty[s]),
            .has_wr   (wr_tok[s]),
            .has_rd   (rd_tok[s])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSLICE; s++) begin
            if (vld[s]) rd_data = rd_data | dat[s];
        end
    end

    assign rd_valid = |vld;
    assign full     = &slice_full;
    assign empty    = &slice_empty;
endmodule

module tokring_fifo_chk #(
    parameter int NSLICE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              full,
    input logic              empty,
    input logic [NSLICE-1:0] wr_tok,
    input logic [NSLICE-1:0] rd_tok
);
    function automatic logic [NSLICE-1:0] rot(input logic [NSLICE-1:0] v);
        return (v << 1) | (v >> (NSLICE - 1));
    endfunction

    a_r2_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_tok) == 1);
    a_r4_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_tok) == 1);
    a_r3_wr_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_tok) |-> wr_tok == rot($past(wr_tok)));
    a_r3_wr_pass_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_tok) |-> ($past(wr_en) && !$past(full)));
    a_r4_rd_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_tok) |-> rd_tok == rot($past(rd_tok)));
    a_r4_rd_pass_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_tok) |-> rd_valid);
    a_r6_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> !rd_valid);
    a_r7_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);
endmodule

bind tokring_fifo tokring_fifo_chk #(.NSLICE(NSLICE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty),
    .wr_tok   (wr_tok),
    .rd_tok   (rd_tok)
);

// File: tb/sim_tokring_fifo.sv
module sim_tokring_fifo;
    localparam int N = 3;
    localparam int W = 9;
    localparam int D = 4;
    localparam int CAP = N * D;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] first_load_n = '1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic rd_valid, full, empty;
    logic [N-1:0] slice_full, slice_empty, wr_tok, rd_tok;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tokring_fifo #(.NSLICE(N), .WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
        .slice_full(slice_full), .slice_empty(slice_empty),
        .wr_tok(wr_tok), .rd_tok(rd_tok)
    );

    int total = 0, fails = 0;
    logic [W-1:0] q[$];
    int cnt_m [N];
    int wslot, wloc, rslot, rloc;
    bit exp_valid;
    logic [W-1:0] exp_data;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] onehot_of(input int s);
        return N'(1) << s;
    endfunction

    function automatic logic [N-1:0] flags_m(input bit want_full);
        logic [N-1:0] f;
        for (int s = 0; s < N; s++) f[s] = want_full ? (cnt_m[s] == D) : (cnt_m[s] == 0);
        return f;
    endfunction

    task automatic model_reset(input int first);
        q.delete();
        for (int s = 0; s < N; s++) cnt_m[s] = 0;
        wslot = first; rslot = first; wloc = 0; rloc = 0;
        exp_valid = 1'b0; exp_data = '0;
    endtask

    task automatic do_reset(input int first);
        wr_en = 1'b0; rd_en = 1'b0;
        first_load_n = ~onehot_of(first);
        rst_n = 1'b0;
        model_reset(first);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 wr_tok in reset", 32'(wr_tok), 32'(onehot_of(first)));
        check("R1 rd_tok in reset", 32'(rd_tok), 32'(onehot_of(first)));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty after reset", 32'(empty), 1);
        check("R1 full after reset", 32'(full), 0);
        check("R1 rd_valid after reset", 32'(rd_valid), 0);
        check("R1 slice_empty after reset", 32'(slice_empty), 32'({N{1'b1}}));
        check("R1 wr_tok after reset", 32'(wr_tok), 32'(onehot_of(first)));
    endtask

    // Called at a falling edge: compare, then drive the next cycle
    task automatic cycle(input bit w, input bit r);
        bit wa, ra;
        check("R2 write token holder", 32'(wr_tok), 32'(onehot_of(wslot)));
        check("R4 read token holder", 32'(rd_tok), 32'(onehot_of(rslot)));
        check("R6 composite empty", 32'(empty), 32'(q.size() == 0));
        check("R7 composite full", 32'(full), 32'(q.size() == CAP));
        check("R8 slice_full", 32'(slice_full), 32'(flags_m(1'b1)));
        check("R8 slice_empty", 32'(slice_empty), 32'(flags_m(1'b0)));
        check("R5 rd_valid", 32'(rd_valid), 32'(exp_valid));
        if (exp_valid) check("R5 rd_data order", 32'(rd_data), 32'(exp_data));
        wa = w && (q.size() < CAP);
        ra = r && (q.size() > 0);
        wr_en = w; rd_en = r;
        wr_data = W'($urandom);
        exp_valid = ra;
        if (ra) begin
            exp_data = q.pop_front();
            cnt_m[rslot]--;
            rloc++;
            if (rloc == D) begin rloc = 0; rslot = (rslot + 1) % N; end
        end
        if (wa) begin
            q.push_back(wr_data);
            cnt_m[wslot]++;
            wloc++;
            if (wloc == D) begin wloc = 0; wslot = (wslot + 1) % N; end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(0);
        // R6: reads on an empty buffer are ignored
        repeat (3) cycle(1'b0, 1'b1);
        // R3/R7: fill completely across every slice, then push more (dropped)
        repeat (CAP) cycle(1'b1, 1'b0);
        repeat (3) cycle(1'b1, 1'b0);
        check("R7 full reached", 32'(full), 1);
        // R9: simultaneous read and write while full: only the read happens
        cycle(1'b1, 1'b1);
        // R9: simultaneous read and write in the middle
        repeat (6) cycle(1'b1, 1'b1);
        // R4/R7: drain everything, dropped words must not appear
        repeat (CAP + 3) cycle(1'b0, 1'b1);
        check("R6 empty after drain", 32'(empty), 1);
        // R9: simultaneous on empty: only the write happens
        cycle(1'b1, 1'b1);
        // random mix, write-heavy then read-heavy
        for (int i = 0; i < 600; i++) cycle(($urandom % 4) != 0, ($urandom % 3) == 0);
        for (int i = 0; i < 600; i++) cycle(($urandom % 3) == 0, ($urandom % 4) != 0);
        // R10: start the ring at the last slice so wrap to slice 0 is first
        do_reset(N - 1);
        repeat (D + 1) cycle(1'b1, 1'b0);
        check("R10 write token wrapped to slice 0", 32'(wr_tok), 32'(onehot_of(0)));
        repeat (D + 1) cycle(1'b0, 1'b1);
        check("R10 read token wrapped to slice 0", 32'(rd_tok), 32'(onehot_of(0)));
        for (int i = 0; i < 800; i++) cycle($urandom % 2, $urandom % 2);
        repeat (CAP + 2) cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule